// File: doc/BRIEF.md
# Serial zero-one-one pattern detector

This block watches a one-bit serial stream, one bit per clock, and flags every completed occurrence of the pattern zero, one, one. After a hit it does not lock up. It leaves the hit condition on either input value and keeps searching, so later occurrences are reported too.

A parameter selects one of two output forms when the design is elaborated:

- **Registered form.** The flag comes from a dedicated fourth state. It is high for one cycle, starting at the clock edge that samples the final one.
- **Combinational form.** Only three states are used. The flag is driven combinationally while the machine is waiting for the final one and the input is one. The flag therefore appears in the same cycle as the bit that completes the pattern.

Top module: `serial_trio_detector`

## Requirements
- R1: While rst_ni is low the machine is in its idle state and detect_o is 0. After release, no detection is possible until a zero has been sampled.
- R2: In the idle state, sampled ones keep the machine idle, so a stream of only ones never raises detect_o.
- R3: After a zero has been sampled, any number of further zeros keeps the machine waiting for a one. The pattern is then completed by one, one, whatever the length of the zero run before it.
- R4: If a zero is sampled after a single one (the pattern being 0,1,0), the machine returns to the one-zero-seen state. The sequence 0,1,0,1,1 therefore detects only at its last bit.
- R5: With MEALY_MODE=0, detect_o is 1 for exactly the one cycle after the clock edge that sampled the final one. It is never high on two consecutive cycles.
- R6: With MEALY_MODE=1, detect_o is 1 during the cycle in which the machine waits for the final one and din_i is 1, before the edge that samples it. It is never 1 while din_i is 0.
- R7: After a hit the search restarts. A following zero counts as the start of a new pattern. A following one requires a fresh zero, so 0,1,1,1,1 detects once and 0,1,1,0,1,1 detects twice.
- R8: With MEALY_MODE=1 the dedicated hit state is never entered. Every state has exactly one successor for each input value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| din_i | input | 1 | Serial data bit, sampled on the rising edge |
| detect_o | output | 1 | Pattern found flag |

## Verification
The assertions check the following on every cycle:

- The idle state holds on ones.
- A zero after a single one falls back to the one-zero-seen state.
- The registered flag never lasts two cycles.
- The combinational flag only occurs with a one on the input, and is always followed by a return to idle.
- The hit state stays unused in the combinational form.

Only the bench's scenarios can show that whole streams give the right number and timing of hits. This includes long zero runs, back-to-back patterns, trailing ones after a hit, and a reset that lands in the middle of a partial pattern.

// File: rtl/trio_det_pkg.sv
package trio_det_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ZERO = 2'd1,
    ST_ONE  = 2'd2,
    ST_HIT  = 2'd3
  } det_state_e;
endpackage

// File: rtl/trio_det_next.sv
module trio_det_next
  import trio_det_pkg::*;
#(
  parameter bit MEALY_MODE = 1'b0
) (
  input  det_state_e cur_i,
  input  logic       din_i,
  output det_state_e nxt_o,
  output logic       hit_o
);
  // complete and conflict-free: one successor per state per input value
  always_comb begin
    unique case (cur_i)
      ST_IDLE: nxt_o = din_i ? ST_IDLE : ST_ZERO;
      ST_ZERO: nxt_o = din_i ? ST_ONE  : ST_ZERO;
      ST_ONE:  nxt_o = din_i ? (MEALY_MODE ? ST_IDLE : ST_HIT) : ST_ZERO;
      ST_HIT:  nxt_o = din_i ? ST_IDLE : ST_ZERO;
      default: nxt_o = ST_IDLE;
    endcase
  end

  assign hit_o = (cur_i == ST_ONE) && din_i;
endmodule

// File: rtl/trio_det_reg.sv
module trio_det_reg
  import trio_det_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  det_state_e nxt_i,
  output det_state_e cur_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cur_o <= ST_IDLE;
    else         cur_o <= nxt_i;
  end
endmodule

// File: rtl/serial_trio_detector.sv
module serial_trio_detector
  import trio_det_pkg::*;
#(
  parameter bit MEALY_MODE = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic din_i,
  output logic detect_o
);
  det_state_e cur_q;
  det_state_e nxt_d;
  logic       hit_comb;

  trio_det_next #(.MEALY_MODE(MEALY_MODE)) u_next (
    .cur_i (cur_q),
    .din_i (din_i),
    .nxt_o (nxt_d),
    .hit_o (hit_comb)
  );

  trio_det_reg u_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .nxt_i  (nxt_d),
    .cur_o  (cur_q)
  );

  generate
    if (MEALY_MODE) begin : g_mealy
      assign detect_o = hit_comb;

      a_r6_flag_needs_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
        detect_o |-> din_i);
      a_r7_mealy_rearm: assert property (@(posedge clk_i) disable iff (!rst_ni)
        detect_o |=> (cur_q == ST_IDLE));
      a_r8_no_hit_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cur_q != ST_HIT);
    end else begin : g_moore
      assign detect_o = (cur_q == ST_HIT);

      a_r5_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        detect_o |=> !detect_o);
      a_r5_after_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cur_q == ST_ONE && din_i) |=> detect_o);
    end
  endgenerate

  a_r2_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_q == ST_IDLE && din_i) |=> (cur_q == ST_IDLE && !detect_o));
  a_r4_fallback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_q == ST_ONE && !din_i) |=> (cur_q == ST_ZERO));
  a_r3_zero_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_q == ST_ZERO && !din_i) |=> (cur_q == ST_ZERO));
endmodule

// File: tb/serial_trio_detector_tb.sv
module serial_trio_detector_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic din = 1'b1;
  logic z_moore, z_mealy;
  int   n_chk = 0;
  int   n_fail = 0;
  int   cyc = 0;

  // model state
  logic [1:0] hist = 2'b11;
  logic       moore_exp = 1'b0;

  always #2.5 clk = ~clk;

  serial_trio_detector #(.MEALY_MODE(1'b0)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .din_i(din), .detect_o(z_moore));
  serial_trio_detector #(.MEALY_MODE(1'b1)) u_dut_mealy (
    .clk_i(clk), .rst_ni(rst_n), .din_i(din), .detect_o(z_mealy));

  localparam int NV = 24;
  localparam logic [NV-1:0] STIM = 24'b1101_1011_1001_0110_1011_0000;

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // drive at negedge, check both outputs, then clock and update model
  task automatic step(input logic b, input string req);
    logic mealy_exp;
    @(negedge clk);
    din = b;
    #1;
    mealy_exp = (hist == 2'b01) && b;
    check({req, " mealy R6"}, z_mealy, mealy_exp);
    check({req, " moore R5"}, z_moore, moore_exp);
    @(posedge clk);
    moore_exp = mealy_exp;
    hist = {hist[0], b};
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    din = 1'b1;
    #1;
    check("R1 reset moore", z_moore, 1'b0);
    check("R1 reset mealy", z_mealy, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    hist = 2'b11;
    moore_exp = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    // vector walk, R3 R4 R7 patterns mixed
    for (int i = NV - 1; i >= 0; i--) step(STIM[i], "R3 vector");
    // R2: run of ones
    do_reset();
    for (int i = 0; i < 8; i++) step(1'b1, "R2 ones");
    // R3: long zero run then 1,1
    for (int i = 0; i < 10; i++) step(1'b0, "R3 zeros");
    step(1'b1, "R3"); step(1'b1, "R3"); step(1'b0, "R3"); step(1'b1, "R3");
    // R4: 0,1,0,1,1
    step(1'b0, "R4"); step(1'b1, "R4"); step(1'b0, "R4"); step(1'b1, "R4"); step(1'b1, "R4");
    // R7: trailing ones need a fresh zero
    step(1'b1, "R7"); step(1'b1, "R7"); step(1'b1, "R7");
    // R7: back to back
    step(1'b0, "R7"); step(1'b1, "R7"); step(1'b1, "R7");
    step(1'b0, "R7"); step(1'b1, "R7"); step(1'b1, "R7"); step(1'b0, "R7");
    // R1: reset mid-pattern discards 0,1
    step(1'b0, "R1"); step(1'b1, "R1");
    do_reset();
    step(1'b1, "R1 post");
    step(1'b1, "R1 post");
    check("R1 no hit after reset", z_moore | z_mealy, 1'b0);
    // R8: mealy hit then 0 still rearms
    step(1'b0, "R8"); step(1'b1, "R8"); step(1'b1, "R8"); step(1'b0, "R8");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule